// File: doc/BRIEF.md
# Multi-Warp Dual-Issue Scheduler with Register Scoreboard

This block sits at the issue stage of a throughput-oriented processor that keeps many hardware warp contexts resident at once. Every cycle it looks at the two oldest buffered instructions of every warp, decides which warps could issue without a register hazard, and picks at most one of them by round-robin. The chosen warp always issues its older instruction and, if the younger one is independent of it and also hazard-free, issues that one too in the same cycle.

Hazards on slow results are tracked by a scoreboard holding one bit per architectural register per warp. Issuing a long-latency instruction marks its destination; a writeback completion notice from the execution side clears it. While a warp waits on such a result the other warps keep issuing, so memory latency is hidden by interleaving rather than by stalling. Fetch, execution and divergence handling are outside this block; the issue outputs name the warp and which of its two buffered instructions left.

Top module: `warp_dual_issue`

## Requirements
- R1: After reset every scoreboard bit is clear, no issue is reported while no instruction is valid, and the first warp granted is the lowest-numbered ready warp (warp 0 when it is ready).
- R2: Each buffered instruction is a 14-bit field at `ins_bus[(warp*2+slot)*14 +: 14]` holding, from the top bit down, valid (bit 13), long-latency (bit 12), destination (11:8), source A (7:4), source B (3:0); slot 1 issues only in a cycle where slot 0 of the same warp issues, and at most one warp issues per cycle.
- R3: Slot 0 of a warp is ready only when it is valid and none of its destination, source A or source B registers is marked in that warp's scoreboard; a warp whose slot 0 is not ready is never selected.
- R4: Issuing a long-latency instruction from either slot marks its destination register for that warp from the next cycle on; short-latency issues mark nothing.
- R5: Among ready warps the grant goes to the first one found searching upward from the warp that issued most recently, wrapping from the highest warp index back to 0.
- R6: Slot 1 issues only if it is valid, none of its three registers is marked, and neither of its sources nor its destination equals the slot 0 destination.
- R7: A writeback notice clears the scoreboard bit of exactly the named warp and register, effective from the next cycle.
- R8: When a writeback notice and a long-latency issue name the same warp and register in one cycle, the bit ends up marked.
- R9: A warp blocked on the scoreboard does not prevent another ready warp from issuing in the same cycle.
- R10: Readiness uses the registered scoreboard, so a writeback arriving in a cycle does not unblock a dependent instruction until the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_bus | input | NW*2*14 | Two buffered instructions per warp, packed as in R2 |
| wb_vld | input | 1 | Writeback completion notice valid |
| wb_warp | input | log2(NW) | Warp of the completing result |
| wb_reg | input | 4 | Register of the completing result |
| iss_warp | output | log2(NW) | Warp granted this cycle |
| iss0_vld | output | 1 | Slot 0 of `iss_warp` issues this cycle |
| iss1_vld | output | 1 | Slot 1 of `iss_warp` issues this cycle |

## Verification
The bench aims at the pair rule for slot 1 with each of the three conflict kinds against the slot 0 destination (read on A, read on B, rewrite), since a design that only checked sources would dual-issue a write-after-write pair and reorder results. It marks registers from both slots and then presents readers and writers of them, catching a scoreboard that forgets slot 1 or ignores destinations, and it lands a writeback together with a new marking on the same bit, which a clear-wins design would lose, leaving a later reader issuing too early. Round-robin is driven across the wrap from the top warp index to warp 0, where an off-by-one pointer would starve one side, and a blocked warp is held beside a ready one to show the ready one is not stalled. Writeback timing is sampled in the arrival cycle to confirm no early release.

// File: rtl/wdi_pkg.sv
`timescale 1ns/1ps
package wdi_pkg;

    parameter int WARPS = 64;
    parameter int REGS  = 16;
    localparam int REG_W = $clog2(REGS);

    typedef struct packed {
        logic             vld;
        logic             lng;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    function automatic logic regs_free(input instr_t ins, input logic [REGS-1:0] row);
        return !row[ins.rd] && !row[ins.ra] && !row[ins.rb];
    endfunction

    function automatic logic pair_indep(input instr_t older, input instr_t younger);
        return (younger.ra != older.rd) && (younger.rb != older.rd) &&
               (younger.rd != older.rd);
    endfunction

endpackage

// File: rtl/wdi_scoreboard.sv
`timescale 1ns/1ps
module wdi_scoreboard
    import wdi_pkg::*;
#(
    parameter int NW = WARPS,
    localparam int WW = $clog2(NW)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set0,
    input  logic [REG_W-1:0]   set0_reg,
    input  logic               set1,
    input  logic [REG_W-1:0]   set1_reg,
    input  logic [WW-1:0]      set_warp,
    input  logic               clr,
    input  logic [WW-1:0]      clr_warp,
    input  logic [REG_W-1:0]   clr_reg,
    output logic [NW*REGS-1:0] marks
);

    logic [REGS-1:0] row_q [NW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NW; w++) row_q[w] <= '0;
        end else begin
            if (clr) row_q[clr_warp][clr_reg] <= 1'b0;
            // marking is applied after clearing so it wins on a shared bit
            if (set0) row_q[set_warp][set0_reg] <= 1'b1;
            if (set1) row_q[set_warp][set1_reg] <= 1'b1;
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_flat
        assign marks[w*REGS +: REGS] = row_q[w];
    end

endmodule

// File: rtl/wdi_ready.sv
`timescale 1ns/1ps
module wdi_ready
    import wdi_pkg::*;
(
    input  instr_t          ins0,
    input  instr_t          ins1,
    input  logic [REGS-1:0] row,
    output logic            rdy0,
    output logic            rdy1
);

    assign rdy0 = ins0.vld && regs_free(ins0, row);
    assign rdy1 = ins1.vld && regs_free(ins1, row) && pair_indep(ins0, ins1);

endmodule

// File: rtl/wdi_rr_pick.sv
`timescale 1ns/1ps
module wdi_rr_pick #(
    parameter int NW = 64,
    localparam int WW = $clog2(NW)
) (
    input  logic [NW-1:0] req,
    input  logic [WW-1:0] last,
    output logic          gnt_vld,
    output logic [WW-1:0] gnt_idx
);

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= NW; k++) begin
            int idx;
            idx = int'(last) + k;
            if (idx >= NW) idx = idx - NW;
            if (!gnt_vld && req[idx]) begin
                gnt_vld = 1'b1;
                gnt_idx = WW'(idx);
            end
        end
    end

endmodule

// File: rtl/warp_dual_issue.sv
`timescale 1ns/1ps
module warp_dual_issue
    import wdi_pkg::*;
#(
    parameter int NW = WARPS,
    localparam int WW = $clog2(NW),
    localparam int BUS_W = NW * 2 * INSTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] ins_bus,
    input  logic             wb_vld,
    input  logic [WW-1:0]    wb_warp,
    input  logic [REG_W-1:0] wb_reg,
    output logic [WW-1:0]    iss_warp,
    output logic             iss0_vld,
    output logic             iss1_vld
);

    instr_t            slot0 [NW];
    instr_t            slot1 [NW];
    logic [NW-1:0]     rdy0;
    logic [NW-1:0]     rdy1;
    logic [NW*REGS-1:0] sb_q;
    logic [WW-1:0]     last_q;
    logic              gnt_vld;
    logic [WW-1:0]     gnt_idx;

    for (genvar w = 0; w < NW; w++) begin : g_warp
        assign slot0[w] = instr_t'(ins_bus[(w*2)*INSTR_W +: INSTR_W]);
        assign slot1[w] = instr_t'(ins_bus[(w*2+1)*INSTR_W +: INSTR_W]);

        wdi_ready u_rdy (
            .ins0 (slot0[w]),
            .ins1 (slot1[w]),
            .row  (sb_q[w*REGS +: REGS]),
            .rdy0 (rdy0[w]),
            .rdy1 (rdy1[w])
        );
    end

    wdi_rr_pick #(.NW(NW)) u_pick (
        .req     (rdy0),
        .last    (last_q),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    assign iss_warp = gnt_idx;
    assign iss0_vld = gnt_vld;
    assign iss1_vld = gnt_vld && rdy1[gnt_idx];

    always_ff @(posedge clk) begin
        if (rst)          last_q <= WW'(NW - 1);
        else if (gnt_vld) last_q <= gnt_idx;
    end

    wdi_scoreboard #(.NW(NW)) u_sb (
        .clk      (clk),
        .rst      (rst),
        .set0     (iss0_vld && slot0[gnt_idx].lng),
        .set0_reg (slot0[gnt_idx].rd),
        .set1     (iss1_vld && slot1[gnt_idx].lng),
        .set1_reg (slot1[gnt_idx].rd),
        .set_warp (gnt_idx),
        .clr      (wb_vld),
        .clr_warp (wb_warp),
        .clr_reg  (wb_reg),
        .marks    (sb_q)
    );

endmodule

// File: rtl/wdi_checker.sv
`timescale 1ns/1ps
module wdi_checker
    import wdi_pkg::*;
#(
    parameter int NW = WARPS,
    localparam int WW = $clog2(NW),
    localparam int BUS_W = NW * 2 * INSTR_W
) (
    input logic               clk,
    input logic               rst,
    input logic [BUS_W-1:0]   ins_bus,
    input logic               wb_vld,
    input logic [WW-1:0]      wb_warp,
    input logic [REG_W-1:0]   wb_reg,
    input logic [WW-1:0]      iss_warp,
    input logic               iss0_vld,
    input logic               iss1_vld,
    input logic [NW*REGS-1:0] sb_q
);

    instr_t          c0, c1;
    logic [REGS-1:0] crow;
    int              bit0, bit1, wbit;
    logic            hit;

    always_comb begin
        c0   = instr_t'(ins_bus[(int'(iss_warp)*2)*INSTR_W +: INSTR_W]);
        c1   = instr_t'(ins_bus[(int'(iss_warp)*2+1)*INSTR_W +: INSTR_W]);
        crow = sb_q[int'(iss_warp)*REGS +: REGS];
        bit0 = int'(iss_warp)*REGS + int'(c0.rd);
        bit1 = int'(iss_warp)*REGS + int'(c1.rd);
        wbit = int'(wb_warp)*REGS + int'(wb_reg);
        hit  = (iss0_vld && c0.lng && bit0 == wbit) || (iss1_vld && c1.lng && bit1 == wbit);
    end

    a_r2_pair_order: assert property (@(posedge clk) disable iff (rst)
        iss1_vld |-> iss0_vld);

    a_r3_slot0_clean: assert property (@(posedge clk) disable iff (rst)
        iss0_vld |-> (c0.vld && !crow[c0.rd] && !crow[c0.ra] && !crow[c0.rb]));

    a_r6_slot1_indep: assert property (@(posedge clk) disable iff (rst)
        iss1_vld |-> (c1.vld && c1.ra != c0.rd && c1.rb != c0.rd && c1.rd != c0.rd
                      && !crow[c1.rd] && !crow[c1.ra] && !crow[c1.rb]));

    a_r4_mark_slot0: assert property (@(posedge clk) disable iff (rst)
        (iss0_vld && c0.lng) |=> sb_q[$past(bit0)]);

    a_r4_mark_slot1: assert property (@(posedge clk) disable iff (rst)
        (iss1_vld && c1.lng) |=> sb_q[$past(bit1)]);

    a_r7_wb_clears: assert property (@(posedge clk) disable iff (rst)
        (wb_vld && !hit) |=> !sb_q[$past(wbit)]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (wb_vld && hit) |=> sb_q[$past(wbit)]);

endmodule

bind warp_dual_issue wdi_checker #(.NW(NW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ins_bus  (ins_bus),
    .wb_vld   (wb_vld),
    .wb_warp  (wb_warp),
    .wb_reg   (wb_reg),
    .iss_warp (iss_warp),
    .iss0_vld (iss0_vld),
    .iss1_vld (iss1_vld),
    .sb_q     (sb_q)
);

// File: tb/warp_dual_issue_tb.sv
`timescale 1ns/1ps
module warp_dual_issue_tb;
    import wdi_pkg::*;

    localparam int NW = 64;
    localparam int WW = $clog2(NW);
    localparam int BUS_W = NW * 2 * INSTR_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [BUS_W-1:0] ins_bus = '0;
    logic             wb_vld = 1'b0;
    logic [WW-1:0]    wb_warp = '0;
    logic [REG_W-1:0] wb_reg = '0;
    logic [WW-1:0]    iss_warp;
    logic             iss0_vld;
    logic             iss1_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    warp_dual_issue #(.NW(NW)) u_dut (
        .clk(clk), .rst(rst), .ins_bus(ins_bus),
        .wb_vld(wb_vld), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .iss_warp(iss_warp), .iss0_vld(iss0_vld), .iss1_vld(iss1_vld)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // check the three issue outputs; warp compared only when slot 0 issues
    task automatic expect_iss(input string req, input bit e0, input bit e1, input int ew);
        #1;
        check({req, " slot0"}, int'(iss0_vld), int'(e0));
        check({req, " slot1"}, int'(iss1_vld), int'(e1));
        if (e0) check({req, " warp"}, int'(iss_warp), ew);
    endtask

    task automatic put(input int w, input int s, input bit v, input bit l,
                       input int rd, input int ra, input int rb);
        instr_t t;
        t.vld = v; t.lng = l;
        t.rd = REG_W'(rd); t.ra = REG_W'(ra); t.rb = REG_W'(rb);
        ins_bus[(w*2+s)*INSTR_W +: INSTR_W] = t;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wb(input int w, input int r);
        wb_vld = 1'b1; wb_warp = WW'(w); wb_reg = REG_W'(r);
    endtask

    task automatic t_reset();
        ins_bus = '0;
        expect_iss("R1 idle", 0, 0, 0);
        put(0, 0, 1, 0, 15, 14, 13);
        put(0, 1, 1, 0, 12, 11, 10);
        expect_iss("R1 clear scoreboard, warp0 first", 1, 1, 0);
        cyc();
        ins_bus = '0;
    endtask

    task automatic t_round_robin();
        // last issued was warp 0; warps 0 and 63 both ready
        put(0, 0, 1, 0, 1, 2, 3);
        put(63, 0, 1, 0, 1, 2, 3);
        expect_iss("R5 after warp0 picks 63", 1, 0, 63);
        cyc();
        expect_iss("R5 wrap 63 to 0", 1, 0, 0);
        cyc();
        put(30, 0, 1, 0, 1, 2, 3);
        expect_iss("R5 search upward from 0", 1, 0, 30);
        cyc();
        expect_iss("R5 after 30 picks 63", 1, 0, 63);
        cyc();
        ins_bus = '0;
    endtask

    task automatic t_pairs();
        put(12, 0, 1, 0, 3, 0, 1);
        put(12, 1, 1, 0, 5, 3, 2);
        expect_iss("R6 slot1 reads A of dest", 1, 0, 12);
        put(12, 1, 1, 0, 5, 2, 3);
        expect_iss("R6 slot1 reads B of dest", 1, 0, 12);
        put(12, 1, 1, 0, 3, 2, 4);
        expect_iss("R6 slot1 rewrites dest", 1, 0, 12);
        put(12, 1, 1, 0, 6, 2, 4);
        expect_iss("R2 independent pair dual issues", 1, 1, 12);
        put(12, 0, 0, 0, 3, 0, 1);
        expect_iss("R2 slot1 alone never issues", 0, 0, 0);
        cyc();
        ins_bus = '0;
    endtask

    task automatic t_scoreboard();
        put(3, 0, 1, 1, 4, 0, 0);
        expect_iss("R4 long issue warp3", 1, 0, 3);
        cyc();
        ins_bus = '0;
        put(3, 0, 1, 0, 5, 4, 1);
        put(9, 0, 1, 0, 1, 2, 3);
        expect_iss("R9 blocked warp3, warp9 issues", 1, 0, 9);
        cyc();
        put(9, 0, 0, 0, 0, 0, 0);
        expect_iss("R3 reader of marked reg held", 0, 0, 0);
        put(3, 0, 1, 0, 4, 1, 2);
        expect_iss("R3 writer of marked reg held", 0, 0, 0);
        put(7, 0, 1, 0, 1, 4, 4);
        expect_iss("R4 mark is per warp", 1, 0, 7);
        cyc();
        put(7, 0, 0, 0, 0, 0, 0);
        wb(3, 4);
        expect_iss("R10 no release in wb cycle", 0, 0, 0);
        cyc();
        wb_vld = 1'b0;
        expect_iss("R7 released after wb", 1, 0, 3);
        cyc();
        ins_bus = '0;
    endtask

    task automatic t_slot1_marks();
        put(5, 0, 1, 1, 7, 0, 1);
        put(5, 1, 1, 1, 8, 2, 3);
        expect_iss("R4 two long issues", 1, 1, 5);
        cyc();
        put(5, 0, 1, 0, 1, 2, 3);
        put(5, 1, 1, 0, 4, 8, 9);
        expect_iss("R4 slot1 mark blocks slot1", 1, 0, 5);
        cyc();
        put(5, 0, 1, 0, 1, 7, 3);
        expect_iss("R4 slot0 mark blocks warp", 0, 0, 0);
        wb(5, 7);
        cyc();
        wb(5, 8);
        cyc();
        wb_vld = 1'b0;
        put(5, 1, 1, 0, 4, 8, 9);
        expect_iss("R7 both cleared", 1, 1, 5);
        cyc();
        ins_bus = '0;
    endtask

    task automatic t_set_wins();
        put(10, 0, 1, 1, 6, 0, 1);
        wb(10, 6);
        expect_iss("R8 long issue with wb same bit", 1, 0, 10);
        cyc();
        wb_vld = 1'b0;
        put(10, 0, 1, 0, 2, 6, 1);
        expect_iss("R8 bit stays marked", 0, 0, 0);
        wb(10, 5);
        cyc();
        wb_vld = 1'b0;
        expect_iss("R7 other register wb leaves mark", 0, 0, 0);
        wb(10, 6);
        cyc();
        wb_vld = 1'b0;
        expect_iss("R7 matching wb releases", 1, 0, 10);
        cyc();
        ins_bus = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_round_robin();
        t_pairs();
        t_scoreboard();
        t_slot1_marks();
        t_set_wins();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule